// File: doc/BRIEF.md
# Single-Bit Carrier Correlator (I/Q Demodulator)

This block recovers the in-phase and quadrature content of a carrier from a one-bit delta-sigma bitstream. A free-running numerically controlled oscillator (NCO) addresses a small sine table. For every clock the incoming bit picks either the table value or its negation, so no multiplier is needed. The signed result is added into an I accumulator using the cosine coefficient and a Q accumulator using the sine coefficient. After a programmed number of clocks the block presents the I/Q pair with a one-cycle strobe. The next window then starts at once. Angle extraction and symbol decisions are left to downstream logic.

Window commands carry a length in sampling clocks and a table phase offset. Commands pass through a one-deep holding slot, so the next window can be queued while the current one runs. A queued command is taken up on the final sample of the running window, which keeps successive windows gapless. While the slot is occupied, new commands stall. A build-time option adds a second running-sum stage, giving a triangular (sinc2) weighting in place of the flat (sinc1) one.

Top module: `bitstream_iq_correlator`

## Requirements
- R1: After reset, `cmd_ready` is 1, `iq_valid` is 0, and `i_out` and `q_out` are 0.
- R2: The NCO phase register is 0 after reset and adds `freq_word` on every clock, whether or not a window is running. The table index for a sample is the top TBL_AW bits of that phase plus the running window's `cmd_phase`, modulo 2^TBL_AW.
- R3: Table entry k of N = 2^TBL_AW has this value, with H = N/2 and A = 2^(COEF_W-1)-1. For k < H it is floor(16·A·k·(H-k) / (5·H² - 4·k·(H-k))). For k ≥ H it is the negation of entry k-H. Sine uses index k and cosine uses index k+N/4 (mod N).
- R4: A sample bit of 1 adds the coefficient and a bit of 0 subtracts it. I uses the cosine coefficient and Q uses the sine coefficient.
- R5: A window of length L covers exactly L consecutive sampling clocks. A length of 0 is handled as 1.
- R6: A command is accepted on the clock edge that sees `cmd_valid` high while `cmd_ready` is high. Its first sample falls on edge max(a+2, e+1), where a is the accepting edge and e is the last-sample edge of the previous window. `iq_valid` is high for exactly the cycle after the last sample's edge.
- R7: A command already held when the running window takes its last sample starts on the very next edge, with no idle clock between windows.
- R8: `cmd_ready` is low from the cycle after acceptance until the held command's window begins. A command offered during that time is neither taken nor lost.
- R9: Both accumulators restart from zero at the first sample of every window, so no window carries contents from an earlier one.
- R10: With the double-integration option, the result of a window with samples x0..x(L-1) is the sum of (L-k)·xk. Otherwise it is the plain sum of xk.
- R11: A full-scale input over a 65535-clock window gives the exact result, with no wraparound. For an all-ones input at cosine coefficient +127, I is 8322945.
- R12: Between strobes, `i_out` and `q_out` keep the value of the last completed window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_word | input | PHASE_W | NCO phase increment per clock |
| bit_in | input | 1 | One-bit sample from the modulator |
| cmd_valid | input | 1 | Window command offered |
| cmd_len | input | LEN_W | Window length in sampling clocks (0 means 1) |
| cmd_phase | input | TBL_AW | Table phase offset for the window |
| cmd_ready | output | 1 | Holding slot is free |
| iq_valid | output | 1 | One-cycle result strobe |
| i_out | output | ACC_W | In-phase result, signed |
| q_out | output | ACC_W | Quadrature result, signed |

## Verification
Two events can fall on the same clock edge: the last sample of the running window, with its result capture, and the start of the queued window, with its accumulator clear and new phase offset. The bench provokes this by keeping commands waiting back-to-back, with lengths down to one clock and with offers landing both before and exactly on a final-sample edge. Each strobe is judged in two ways. Its cycle must match the start-edge formula, and its values must match a bench model that sums only that window's own samples with the window's own offset.

// File: rtl/bic_pkg.sv
package bic_pkg;

    // Integration depth selection for the correlator
    typedef enum logic {
        INTEG_SINGLE = 1'b0,
        INTEG_DOUBLE = 1'b1
    } integ_e;

    // Half-period rational sine approximation, nonnegative for 0 <= k <= h
    function automatic longint half_wave(longint k, longint h, longint amp);
        longint p;
        p = k * (h - k);
        return (amp * 16 * p) / (5 * h * h - 4 * p);
    endfunction

    // Full-period table value at index idx of an n-entry table
    function automatic longint wave_at(longint idx, longint n, longint amp);
        longint h;
        longint k;
        h = n / 2;
        k = idx % n;
        if (k < h) begin
            return half_wave(k, h, amp);
        end
        return -half_wave(k - h, h, amp);
    endfunction

endpackage

// File: rtl/bic_nco.sv
module bic_nco #(
    parameter int PHASE_W = 32,
    parameter int TBL_AW  = 5,
    parameter int COEF_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PHASE_W-1:0]       freq_word,
    input  logic [TBL_AW-1:0]        offset,
    output logic signed [COEF_W-1:0] cos_c,
    output logic signed [COEF_W-1:0] sin_c
);
    localparam int N   = 1 << TBL_AW;
    localparam int AMP = (1 << (COEF_W - 1)) - 1;
    localparam logic [TBL_AW-1:0] QUARTER = TBL_AW'(N / 4);

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
    } nco_t;

    nco_t st_d, st_q;
    logic signed [COEF_W-1:0] rom [N];
    logic [TBL_AW-1:0] sin_addr;
    logic [TBL_AW-1:0] cos_addr;

    // Coefficient table built at elaboration (R3)
    for (genvar g = 0; g < N; g++) begin : g_rom
        assign rom[g] = COEF_W'(bic_pkg::wave_at(longint'(g), longint'(N), longint'(AMP)));
    end

    always_comb begin
        st_d       = st_q;
        st_d.phase = st_q.phase + freq_word;
        sin_addr   = st_q.phase[PHASE_W-1 -: TBL_AW] + offset;
        cos_addr   = sin_addr + QUARTER;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sin_c = rom[sin_addr];
    assign cos_c = rom[cos_addr];

endmodule

// File: rtl/bic_window_ctl.sv
module bic_window_ctl #(
    parameter int LEN_W  = 16,
    parameter int TBL_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [TBL_AW-1:0] cmd_phase,
    output logic              cmd_ready,
    output logic              win_act,
    output logic              win_first,
    output logic              win_last,
    output logic [TBL_AW-1:0] win_offset
);
    typedef struct packed {
        logic              pend_v;
        logic [LEN_W-1:0]  pend_len;
        logic [TBL_AW-1:0] pend_ph;
        logic              act;
        logic              first;
        logic [LEN_W-1:0]  remain;
        logic [TBL_AW-1:0] ph;
    } ctl_t;

    ctl_t st_d, st_q;
    logic accept;
    logic last;
    logic load;

    always_comb begin
        st_d   = st_q;
        accept = cmd_valid && !st_q.pend_v;
        last   = st_q.act && (st_q.remain == LEN_W'(1));
        load   = st_q.pend_v && (!st_q.act || last);

        if (st_q.act) begin
            st_d.remain = st_q.remain - LEN_W'(1);
            st_d.first  = 1'b0;
            if (last) begin
                st_d.act = 1'b0;
            end
        end

        // Queued window takes over on the final sample edge (R7)
        if (load) begin
            st_d.act    = 1'b1;
            st_d.first  = 1'b1;
            st_d.remain = st_q.pend_len;
            st_d.ph     = st_q.pend_ph;
            st_d.pend_v = 1'b0;
        end

        // One-deep slot, zero length folded to one (R5)
        if (accept) begin
            st_d.pend_v   = 1'b1;
            st_d.pend_len = (cmd_len == '0) ? LEN_W'(1) : cmd_len;
            st_d.pend_ph  = cmd_phase;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_ready  = !st_q.pend_v;
    assign win_act    = st_q.act;
    assign win_first  = st_q.first;
    assign win_last   = last;
    assign win_offset = st_q.ph;

    // R8: an accepted command occupies the slot on the next cycle
    p_accept_fills_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready)
        else $error("p_accept_fills_r8");

    // R7: a held command begins right after the final sample
    p_gapless_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_last && !cmd_ready) |=> (win_act && win_first))
        else $error("p_gapless_r7");

endmodule

// File: rtl/bic_iq_accum.sv
module bic_iq_accum #(
    parameter int              COEF_W = 8,
    parameter int              LEN_W  = 16,
    parameter bic_pkg::integ_e INTEG  = bic_pkg::INTEG_SINGLE,
    localparam int             S1_W   = COEF_W + LEN_W,
    localparam int             ACC_W  = COEF_W + ((INTEG == bic_pkg::INTEG_DOUBLE) ? 2 : 1) * LEN_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     first,
    input  logic                     last,
    input  logic                     bit_in,
    input  logic signed [COEF_W-1:0] cos_c,
    input  logic signed [COEF_W-1:0] sin_c,
    output logic                     valid_o,
    output logic signed [ACC_W-1:0]  i_o,
    output logic signed [ACC_W-1:0]  q_o
);
    typedef struct packed {
        logic signed [S1_W-1:0] s1i;
        logic signed [S1_W-1:0] s1q;
    } st1_t;

    typedef struct packed {
        logic                    v;
        logic signed [ACC_W-1:0] oi;
        logic signed [ACC_W-1:0] oq;
    } out_t;

    st1_t st1_d, st1_q;
    out_t out_d, out_q;
    logic signed [S1_W-1:0]  xi;
    logic signed [S1_W-1:0]  xq;
    logic signed [ACC_W-1:0] tot_i;
    logic signed [ACC_W-1:0] tot_q;

    // Sign selection replaces the multiply (R4); restart on first sample (R9)
    always_comb begin
        st1_d = st1_q;
        xi    = bit_in ? S1_W'(cos_c) : -S1_W'(cos_c);
        xq    = bit_in ? S1_W'(sin_c) : -S1_W'(sin_c);
        if (en) begin
            st1_d.s1i = (first ? '0 : st1_q.s1i) + xi;
            st1_d.s1q = (first ? '0 : st1_q.s1q) + xq;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st1_q <= '0;
        end else begin
            st1_q <= st1_d;
        end
    end

    if (INTEG == bic_pkg::INTEG_DOUBLE) begin : g_sinc2
        typedef struct packed {
            logic signed [ACC_W-1:0] s2i;
            logic signed [ACC_W-1:0] s2q;
        } st2_t;

        st2_t st2_d, st2_q;

        // Second running sum over the first stage (R10)
        always_comb begin
            st2_d = st2_q;
            if (en) begin
                st2_d.s2i = (first ? '0 : st2_q.s2i) + ACC_W'(st1_d.s1i);
                st2_d.s2q = (first ? '0 : st2_q.s2q) + ACC_W'(st1_d.s1q);
            end
            tot_i = st2_d.s2i;
            tot_q = st2_d.s2q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st2_q <= '0;
            end else begin
                st2_q <= st2_d;
            end
        end
    end else begin : g_sinc1
        always_comb begin
            tot_i = ACC_W'(st1_d.s1i);
            tot_q = ACC_W'(st1_d.s1q);
        end
    end

    always_comb begin
        out_d   = out_q;
        out_d.v = en && last;
        if (en && last) begin
            out_d.oi = tot_i;
            out_d.oq = tot_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign valid_o = out_q.v;
    assign i_o     = out_q.oi;
    assign q_o     = out_q.oq;

    // R11: a positive step onto a nonnegative sum never wraps negative
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !first && xi > 0 && st1_q.s1i >= 0) |=> (st1_q.s1i > $past(st1_q.s1i)))
        else $error("p_no_overflow_r11");

    // R9: the first sample of a window alone forms the first-stage sum
    p_first_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && first) |=> (st1_q.s1q == $past(xq)))
        else $error("p_first_clears_r9");

    // R12: results move only together with the strobe
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(i_o) && $stable(q_o)))
        else $error("p_hold_r12");

endmodule

// File: rtl/bitstream_iq_correlator.sv
module bitstream_iq_correlator #(
    parameter int              PHASE_W = 32,
    parameter int              TBL_AW  = 5,
    parameter int              COEF_W  = 8,
    parameter int              LEN_W   = 16,
    parameter bic_pkg::integ_e INTEG   = bic_pkg::INTEG_SINGLE,
    localparam int             ACC_W   = COEF_W + ((INTEG == bic_pkg::INTEG_DOUBLE) ? 2 : 1) * LEN_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PHASE_W-1:0]      freq_word,
    input  logic                    bit_in,
    input  logic                    cmd_valid,
    input  logic [LEN_W-1:0]        cmd_len,
    input  logic [TBL_AW-1:0]       cmd_phase,
    output logic                    cmd_ready,
    output logic                    iq_valid,
    output logic signed [ACC_W-1:0] i_out,
    output logic signed [ACC_W-1:0] q_out
);
    logic                     win_act;
    logic                     win_first;
    logic                     win_last;
    logic [TBL_AW-1:0]        win_offset;
    logic signed [COEF_W-1:0] cos_c;
    logic signed [COEF_W-1:0] sin_c;

    bic_window_ctl #(
        .LEN_W (LEN_W),
        .TBL_AW(TBL_AW)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_len   (cmd_len),
        .cmd_phase (cmd_phase),
        .cmd_ready (cmd_ready),
        .win_act   (win_act),
        .win_first (win_first),
        .win_last  (win_last),
        .win_offset(win_offset)
    );

    bic_nco #(
        .PHASE_W(PHASE_W),
        .TBL_AW (TBL_AW),
        .COEF_W (COEF_W)
    ) u_nco (
        .clk      (clk),
        .rst_n    (rst_n),
        .freq_word(freq_word),
        .offset   (win_offset),
        .cos_c    (cos_c),
        .sin_c    (sin_c)
    );

    bic_iq_accum #(
        .COEF_W(COEF_W),
        .LEN_W (LEN_W),
        .INTEG (INTEG)
    ) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (win_act),
        .first  (win_first),
        .last   (win_last),
        .bit_in (bit_in),
        .cos_c  (cos_c),
        .sin_c  (sin_c),
        .valid_o(iq_valid),
        .i_o    (i_out),
        .q_o    (q_out)
    );

    // R6: a strobe is always preceded by a running window
    p_strobe_after_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        iq_valid |-> $past(win_act))
        else $error("p_strobe_after_window_r6");

endmodule

// File: tb/bitstream_iq_correlator_bench.sv
module bitstream_iq_correlator_bench;
    localparam int W1 = 8 + 16;
    localparam int W2 = 8 + 32;

    typedef struct {int start; int len; int ph;} win_t;
    typedef struct {int at; longint i1; longint q1; longint i2; longint q2;} res_t;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n = 1'b0;
    logic [31:0]       fw = '0;
    logic              bit_in = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [15:0]       cmd_len = '0;
    logic [4:0]        cmd_phase = '0;
    logic              ready_a, ready_b, v_a, v_b;
    logic signed [W1-1:0] i_a, q_a;
    logic signed [W2-1:0] i_b, q_b;

    bitstream_iq_correlator u_bitstream_iq_correlator (
        .clk(clk), .rst_n(rst_n), .freq_word(fw), .bit_in(bit_in),
        .cmd_valid(cmd_valid), .cmd_len(cmd_len), .cmd_phase(cmd_phase),
        .cmd_ready(ready_a), .iq_valid(v_a), .i_out(i_a), .q_out(q_a));

    bitstream_iq_correlator #(.INTEG(bic_pkg::INTEG_DOUBLE)) u_bitstream_iq_correlator_s2 (
        .clk(clk), .rst_n(rst_n), .freq_word(fw), .bit_in(bit_in),
        .cmd_valid(cmd_valid), .cmd_len(cmd_len), .cmd_phase(cmd_phase),
        .cmd_ready(ready_b), .iq_valid(v_b), .i_out(i_b), .q_out(q_b));

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int last_end = -10;
    int busy_from = -1;
    int busy_to = -2;
    logic [31:0] m_phase = '0;
    longint s1i, s1q, s2i, s2q;
    longint h1i = 0, h1q = 0, h2i = 0, h2q = 0;
    string tag = "R1";
    win_t wq[$];
    win_t issue[$];
    res_t rq[$];

    // Table value per R3, quarter-free form: 32 entries, amplitude 127
    function automatic longint coef(int idx);
        longint k;
        longint p;
        longint mag;
        longint s;
        k = longint'(idx % 32);
        s = 1;
        if (k >= 16) begin
            k = k - 16;
            s = -1;
        end
        p = k * (16 - k);
        mag = (2032 * p) / (1280 - 4 * p);
        return s * mag;
    endfunction

    task automatic check(input string what, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One clock: called just after a negedge, returns at the next negedge
    task automatic tick(input logic b, input logic v, input int len, input int ph, output logic acc);
        logic exp_v;
        logic exp_rdy;
        logic [4:0] addr;
        longint ci, cq, xi, xq;
        int llen, st;
        exp_rdy = !(cyc >= busy_from && cyc <= busy_to);
        check("R8 cmd_ready", longint'(ready_a), longint'(exp_rdy));
        check("R8 cmd_ready dbl", longint'(ready_b), longint'(exp_rdy));
        exp_v = (rq.size() > 0) && (rq[0].at == cyc);
        check("R6 iq_valid", longint'(v_a), longint'(exp_v));
        check("R6 iq_valid dbl", longint'(v_b), longint'(exp_v));
        if (exp_v) begin
            h1i = rq[0].i1; h1q = rq[0].q1; h2i = rq[0].i2; h2q = rq[0].q2;
            void'(rq.pop_front());
            check("R3 R4 i sinc1", longint'(i_a), h1i);
            check("R3 R4 q sinc1", longint'(q_a), h1q);
            check("R10 i sinc2", longint'(i_b), h2i);
            check("R10 q sinc2", longint'(q_b), h2q);
        end else begin
            check("R12 hold i", longint'(i_a), h1i);
            check("R12 hold q dbl", longint'(q_b), h2q);
        end
        bit_in = b;
        cmd_valid = v;
        cmd_len = 16'(len);
        cmd_phase = 5'(ph);
        acc = v && ready_a;
        if (acc) begin
            llen = (len == 0) ? 1 : len;
            st = (cyc + 2 > last_end + 1) ? cyc + 2 : last_end + 1;
            wq.push_back('{st, llen, ph});
            last_end = st + llen - 1;
            busy_from = cyc + 1;
            busy_to = st - 1;
        end
        if (wq.size() > 0 && wq[0].start <= cyc) begin
            if (cyc == wq[0].start) begin
                s1i = 0; s1q = 0; s2i = 0; s2q = 0;
            end
            addr = m_phase[31:27] + 5'(wq[0].ph);
            cq = coef(int'(addr));
            ci = coef(int'(5'(addr + 5'd8)));
            xi = b ? ci : -ci;
            xq = b ? cq : -cq;
            s1i += xi; s1q += xq; s2i += s1i; s2q += s1q;
            if (cyc == wq[0].start + wq[0].len - 1) begin
                rq.push_back('{cyc + 1, s1i, s1q, s2i, s2q});
                void'(wq.pop_front());
            end
        end
        m_phase = m_phase + fw;
        cyc++;
        @(negedge clk);
    endtask

    // bmode: 0 random bits, 1 all ones, 2 all zeros
    task automatic drive_list(input int gap_pct, input int bmode);
        logic acc;
        logic v;
        logic b;
        while (issue.size() > 0 || wq.size() > 0 || rq.size() > 0) begin
            v = (issue.size() > 0) && (($urandom % 100) >= gap_pct);
            b = (bmode == 1) ? 1'b1 : (bmode == 2) ? 1'b0 : 1'($urandom % 2);
            tick(b, v, v ? issue[0].len : 0, v ? issue[0].ph : 0, acc);
            if (acc) void'(issue.pop_front());
        end
        tick(1'b0, 1'b0, 0, 0, acc);
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 195000) begin
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", wd, 195000);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic acc;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fw = 32'h1999_999A;

        // R1 reset state
        check("R1 ready", longint'(ready_a), 1);
        check("R1 valid", longint'(v_a), 0);
        check("R1 i", longint'(i_a), 0);
        check("R1 q dbl", longint'(q_b), 0);

        tag = "R4";
        issue.push_back('{0, 10, 0});
        drive_list(0, 1);

        tag = "R12";
        repeat (6) tick(1'($urandom % 2), 1'b0, 0, 0, acc);

        tag = "R5";
        issue.push_back('{0, 1, 3});
        issue.push_back('{0, 0, 7});
        issue.push_back('{0, 2, 30});
        drive_list(0, 2);

        tag = "R7 R9";
        for (int k = 0; k < 8; k++) issue.push_back('{0, 1 + (k % 4), 4 * k});
        drive_list(0, 0);

        tag = "R2";
        fw = 32'h0C00_0000;
        for (int k = 0; k < 6; k++) issue.push_back('{0, 5 + k, 31 - k});
        drive_list(30, 0);

        tag = "R6 R8";
        fw = 32'h0731_5A01;
        for (int k = 0; k < 40; k++) issue.push_back('{0, 1 + int'($urandom % 24), int'($urandom % 32)});
        drive_list(40, 0);

        // R11 full scale: freeze phase and steer cosine to +127
        tag = "R11";
        fw = '0;
        issue.push_back('{0, 65535, int'(5'(5'd0 - m_phase[31:27]))});
        drive_list(0, 1);
        check("R11 full-scale i", longint'(i_a), 64'sd8322945);
        issue.push_back('{0, 65535, int'(5'(5'd0 - m_phase[31:27]))});
        drive_list(0, 2);
        check("R11 full-scale neg i", longint'(i_a), -64'sd8322945);
        check("R11 full-scale dbl i", longint'(i_b), -64'sd127 * 65535 * 65536 / 2);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule